// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Legality Monitor

This block watches the control pins of a single-rank SDRAM interface. On every rising clock edge it samples chip select, the three strobes, clock enable, the two bank-select bits and address bit 10. It turns these into one command code. For each of four banks it keeps a small model: closed, open, or closing. Each bank carries cycle counters for the minimum intervals. It reports the decoded command, the bank it targets and the auto-precharge request. When the command breaks a state rule or an interval rule, it also raises a one-cycle error with a reason code.

It sits beside a memory controller or on a bus-snoop path as a protocol checker. Every interval is a cycle-count parameter. An offending command is still reported but does not change the bank model, so one mistake does not cause a chain of follow-on errors. The outputs are registered and describe the pins sampled at the previous rising edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high at this edge and the one before, the pins {cs_n, ras_n, cas_n, we_n} decode as follows. cs_n=1 gives DESEL (0) and all other pins are ignored. 0011 gives ACT (2), 0010 gives PRE (6), 0101 gives RD (3), 0100 gives WR (4), 0000 gives MRS (9), 0111 gives NOP (1), 0110 gives BST (5) and 0001 gives AREF (8). Each appears on `cmd` after the edge that sampled it.
- R2: When the strobe pattern is a precharge, addr10=1 turns it into PREA (7), which covers all banks. For RD and WR, `auto_pre` shows addr10; for every other command it is 0. An accepted RD or WR with addr10=1 closes the bank.
- R3: A high-to-low clock-enable transition gives one of three codes. With the refresh pattern it gives SREF (10), which needs every bank closed or else raises STATE. Otherwise it gives PDN (11) when all banks are closed and SUSP (12) when any bank is open or closing. While clock enable is low at both edges the code is HOLD (13) and the other pins are ignored. A low-to-high transition gives WAKE (14).
- R4: ACT to a bank that is open or closing raises STATE (err_code 2). So does RD or WR to a bank that is not open.
- R5: RD or WR earlier than T_RCD cycles after that bank's ACT raises TIME (err_code 1).
- R6: ACT raises TIME if fewer than T_RC cycles have passed since the same bank's ACT, or fewer than T_RRD cycles since any accepted ACT.
- R7: PRE to an open bank, or PREA while any open bank is younger than T_RAS cycles, raises TIME. PRE to a closed bank and PREA with some banks closed raise no error.
- R8: A bank closed by precharge accepts ACT again exactly T_RP cycles after the precharge. A bank closed by auto-precharge accepts ACT again T_AP cycles after the access. Before that it counts as closing.
- R9: MRS raises MODE (err_code 3) unless all banks are closed. AREF raises STATE unless all banks are closed.
- R10: A command that raises an error leaves the bank model and the interval counters as if it had not been issued. The command is still reported on the same cycle as the error.
- R11: After reset, cmd=DESEL, err=0, all banks are closed and every interval counts as already satisfied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank select |
| addr10 | input | 1 | Address bit 10 (all-bank / auto-precharge qualifier) |
| cmd | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank sampled with the command |
| auto_pre | output | 1 | Auto-precharge requested by RD/WR |
| err | output | 1 | One-cycle violation flag |
| err_code | output | 2 | 0 none, 1 TIME, 2 STATE, 3 MODE |

## Verification
The hardest situations to reach from the pins are the exact edges of each interval. One example is an ACT on the last closing cycle of a bank versus the first cycle it is free. Another is PREA one cycle before the youngest open bank reaches T_RAS, or a clock-enable exit while a bank is still open. Random commands seldom land on these cycles. A directed sequence therefore counts cycles from reset and places commands one cycle before and on each boundary. Weighted random traffic then mixes commands, banks and clock-enable drops, and a bench reference model predicts every output.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int T_RCD = 3,
  parameter int T_RC  = 9,
  parameter int T_RRD = 2,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3,
  parameter int T_AP  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic       cke,
  input  logic [1:0] ba,
  input  logic       addr10,
  output logic [3:0] cmd,
  output logic [1:0] cmd_bank,
  output logic       auto_pre,
  output logic       err,
  output logic [1:0] err_code
);
  localparam int NB   = 4;
  localparam int M1   = (T_RC > T_RAS) ? T_RC : T_RAS;
  localparam int M2   = (T_RCD > T_RRD) ? T_RCD : T_RRD;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int PMAX = (T_RP > T_AP) ? T_RP : T_AP;
  localparam int PW   = $clog2(PMAX + 1);

  localparam logic [CW-1:0] CMAX_C = CW'(CMAX);
  localparam logic [CW-1:0] RCD_C  = CW'(T_RCD);
  localparam logic [CW-1:0] RC_C   = CW'(T_RC);
  localparam logic [CW-1:0] RRD_C  = CW'(T_RRD);
  localparam logic [CW-1:0] RAS_C  = CW'(T_RAS);
  localparam logic [PW-1:0] RP_C   = PW'(T_RP - 1);
  localparam logic [PW-1:0] AP_C   = PW'(T_AP - 1);

  localparam logic [3:0] C_DESEL = 4'd0,  C_NOP  = 4'd1,  C_ACT  = 4'd2,  C_RD   = 4'd3;
  localparam logic [3:0] C_WR    = 4'd4,  C_BST  = 4'd5,  C_PRE  = 4'd6,  C_PREA = 4'd7;
  localparam logic [3:0] C_AREF  = 4'd8,  C_MRS  = 4'd9,  C_SREF = 4'd10, C_PDN  = 4'd11;
  localparam logic [3:0] C_SUSP  = 4'd12, C_HOLD = 4'd13, C_WAKE = 4'd14;

  localparam logic [1:0] E_NONE = 2'd0, E_TIME = 2'd1, E_STATE = 2'd2, E_MODE = 2'd3;

  logic          cke_q;
  logic [NB-1:0] open_q, busy, young;
  logic [CW-1:0] since_q [NB];
  logic [PW-1:0] pre_q [NB];
  logic [CW-1:0] any_q;
  logic [3:0]    raw, dec;
  logic [1:0]    code;
  logic          idle_all, access;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    assign busy[g]  = pre_q[g] != '0;
    assign young[g] = open_q[g] && (since_q[g] < RAS_C);
  end

  assign idle_all = (open_q | busy) == '0;

  always_comb begin
    if (cs_n) raw = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  raw = C_ACT;
        3'b010:  raw = addr10 ? C_PREA : C_PRE;
        3'b101:  raw = C_RD;
        3'b100:  raw = C_WR;
        3'b000:  raw = C_MRS;
        3'b111:  raw = C_NOP;
        3'b110:  raw = C_BST;
        default: raw = C_AREF;
      endcase
    end
  end

  assign dec = !cke_q ? (cke ? C_WAKE : C_HOLD)
             : !cke   ? ((raw == C_AREF) ? C_SREF : (idle_all ? C_PDN : C_SUSP))
             : raw;

  assign access = (dec == C_RD) || (dec == C_WR);

  always_comb begin
    code = E_NONE;
    case (dec)
      C_ACT:
        if (open_q[ba] || busy[ba]) code = E_STATE;
        else if (since_q[ba] < RC_C || any_q < RRD_C) code = E_TIME;
      C_RD, C_WR:
        if (!open_q[ba]) code = E_STATE;
        else if (since_q[ba] < RCD_C) code = E_TIME;
      C_PRE:  if (young[ba]) code = E_TIME;
      C_PREA: if (|young) code = E_TIME;
      C_MRS:  if (!idle_all) code = E_MODE;
      C_AREF, C_SREF: if (!idle_all) code = E_STATE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b1;
      cmd      <= C_DESEL;
      cmd_bank <= '0;
      auto_pre <= 1'b0;
      err      <= 1'b0;
      err_code <= E_NONE;
      open_q   <= '0;
      any_q    <= CMAX_C;
      for (int b = 0; b < NB; b++) begin
        since_q[b] <= CMAX_C;
        pre_q[b]   <= '0;
      end
    end else begin
      cke_q    <= cke;
      cmd      <= dec;
      cmd_bank <= ba;
      auto_pre <= addr10 && access;
      err      <= code != E_NONE;
      err_code <= code;
      if (code == E_NONE && dec == C_ACT) any_q <= CW'(1);
      else if (any_q != CMAX_C) any_q <= any_q + 1'b1;
      for (int b = 0; b < NB; b++) begin
        if (since_q[b] != CMAX_C) since_q[b] <= since_q[b] + 1'b1;
        if (busy[b]) pre_q[b] <= pre_q[b] - 1'b1;
        if (code == E_NONE) begin
          if (dec == C_ACT && ba == 2'(b)) begin
            open_q[b]  <= 1'b1;
            since_q[b] <= CW'(1);
          end
          if (access && addr10 && ba == 2'(b)) begin
            open_q[b] <= 1'b0;
            pre_q[b]  <= AP_C;
          end
          if (open_q[b] && ((dec == C_PRE && ba == 2'(b)) || dec == C_PREA)) begin
            open_q[b] <= 1'b0;
            pre_q[b]  <= RP_C;
          end
        end
      end
    end
  end

  assert_desel_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cke && cke_q) |=> (cmd == C_DESEL && !err));

  assert_prea_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cke && cke_q && !ras_n && cas_n && !we_n && addr10) |=> (cmd == C_PREA));

  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_q && !cke) |=> ($stable(open_q) && !err && cmd == C_HOLD));

  assert_rrd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(open_q) > $countones($past(open_q))) |-> ($past(any_q) >= RRD_C));

  assert_open_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q & busy) == '0);

  assert_mrs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS && !err) |-> $past(idle_all));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_test;
  localparam int T_RCD = 3, T_RC = 9, T_RRD = 2, T_RAS = 6, T_RP = 3, T_AP = 6;
  localparam int CMAX = 9;
  localparam bit [2:0] P_ACT = 3'b011, P_PRE = 3'b010, P_RD = 3'b101, P_WR = 3'b100;
  localparam bit [2:0] P_MRS = 3'b000, P_NOP = 3'b111, P_BST = 3'b110, P_REF = 3'b001;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1, cke = 1, addr10 = 0;
  logic [1:0] ba = 0;
  logic [3:0] cmd;
  logic [1:0] cmd_bank, err_code;
  logic auto_pre, err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_open[4], m_since[4], m_pre[4], m_any;
  bit m_cke;

  sdram_cmd_monitor #(.T_RCD(T_RCD), .T_RC(T_RC), .T_RRD(T_RRD), .T_RAS(T_RAS),
                      .T_RP(T_RP), .T_AP(T_AP)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr10(addr10), .cmd(cmd), .cmd_bank(cmd_bank),
    .auto_pre(auto_pre), .err(err), .err_code(err_code));

  always #5 clk = ~clk;

  task automatic model_step(input bit cs, input bit [2:0] p, input bit ck, input int b,
                            input bit a, output int ec, output int ecode, output bit eap);
    int raw;
    bit idle;
    idle = 1;
    for (int i = 0; i < 4; i++) if (m_open[i] != 0 || m_pre[i] > 0) idle = 0;
    if (cs) raw = 0;
    else case (p)
      P_ACT: raw = 2;
      P_PRE: raw = a ? 7 : 6;
      P_RD:  raw = 3;
      P_WR:  raw = 4;
      P_MRS: raw = 9;
      P_NOP: raw = 1;
      P_BST: raw = 5;
      default: raw = 8;
    endcase
    if (!m_cke) ec = ck ? 14 : 13;
    else if (!ck) ec = (raw == 8) ? 10 : (idle ? 11 : 12);
    else ec = raw;
    ecode = 0;
    case (ec)
      2: if (m_open[b] != 0 || m_pre[b] > 0) ecode = 2;
         else if (m_since[b] < T_RC || m_any < T_RRD) ecode = 1;
      3, 4: if (m_open[b] == 0) ecode = 2; else if (m_since[b] < T_RCD) ecode = 1;
      6: if (m_open[b] != 0 && m_since[b] < T_RAS) ecode = 1;
      7: for (int i = 0; i < 4; i++) if (m_open[i] != 0 && m_since[i] < T_RAS) ecode = 1;
      9: if (!idle) ecode = 3;
      8, 10: if (!idle) ecode = 2;
      default: ;
    endcase
    eap = a && (ec == 3 || ec == 4);
    for (int i = 0; i < 4; i++) begin
      if (m_since[i] < CMAX) m_since[i]++;
      if (m_pre[i] > 0) m_pre[i]--;
    end
    if (m_any < CMAX) m_any++;
    if (ecode == 0) begin
      if (ec == 2) begin m_open[b] = 1; m_since[b] = 1; m_any = 1; end
      if ((ec == 3 || ec == 4) && a) begin m_open[b] = 0; m_pre[b] = T_AP - 1; end
      if (ec == 6 && m_open[b] != 0) begin m_open[b] = 0; m_pre[b] = T_RP - 1; end
      if (ec == 7)
        for (int i = 0; i < 4; i++)
          if (m_open[i] != 0) begin m_open[i] = 0; m_pre[i] = T_RP - 1; end
    end
    m_cke = ck;
  endtask

  task automatic issue(input bit cs, input bit [2:0] p, input bit ck, input int b, input bit a,
                       input int xcmd, input int xcode, input string tag);
    int ec, ecode;
    bit eap;
    model_step(cs, p, ck, b, a, ec, ecode, eap);
    @(negedge clk);
    cs_n = cs; {ras_n, cas_n, we_n} = p; cke = ck; ba = 2'(b); addr10 = a;
    @(posedge clk);
    #1;
    n_chk++;
    if (cmd != 4'(ec) || err_code != 2'(ecode) || err != (ecode != 0) || auto_pre != eap
        || cmd_bank != 2'(b)) begin
      n_fail++;
      $display("FAIL %s model: cmd=%0d code=%0d ap=%0d bank=%0d expected cmd=%0d code=%0d ap=%0d bank=%0d",
               tag, cmd, err_code, auto_pre, cmd_bank, ec, ecode, eap, b);
    end
    if (xcmd >= 0 || xcode >= 0) begin
      n_chk++;
      if ((xcmd >= 0 && cmd != 4'(xcmd)) || (xcode >= 0 && err_code != 2'(xcode))) begin
        n_fail++;
        $display("FAIL %s directed: cmd=%0d code=%0d expected cmd=%0d code=%0d",
                 tag, cmd, err_code, xcmd, xcode);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    m_cke = 1; m_any = CMAX;
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_since[i] = CMAX; m_pre[i] = 0; end
    void'($urandom(32'd20250));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    n_chk++;
    if (cmd != 0 || err != 0 || err_code != 0 || auto_pre != 0) begin
      n_fail++;
      $display("FAIL R11 reset: cmd=%0d err=%0d expected cmd=0 err=0", cmd, err);
    end

    issue(0, P_ACT, 1, 0, 0, 2, 0, "R11 first act");
    issue(0, P_ACT, 1, 1, 0, 2, 1, "R6 rrd short");
    issue(0, P_ACT, 1, 1, 0, 2, 0, "R6 R10 rrd met");
    issue(0, P_RD,  1, 1, 0, 3, 1, "R5 rcd short");
    issue(0, P_RD,  1, 2, 0, 3, 2, "R4 read closed");
    issue(0, P_PRE, 1, 1, 0, 6, 1, "R7 ras short");
    issue(0, P_ACT, 1, 0, 0, 2, 2, "R4 act open");
    issue(0, P_PRE, 1, 0, 0, 6, 0, "R7 ras met");
    issue(0, P_ACT, 1, 0, 0, 2, 2, "R8 closing");
    issue(0, P_ACT, 1, 0, 0, 2, 2, "R8 last closing");
    issue(0, P_ACT, 1, 0, 0, 2, 0, "R8 rp met");
    issue(0, P_MRS, 1, 0, 0, 9, 3, "R9 mrs open");
    issue(0, P_REF, 1, 0, 0, 8, 2, "R9 aref open");
    issue(0, P_WR,  1, 1, 1, 4, 0, "R2 write autopre");
    issue(0, P_PRE, 1, 0, 1, 7, 1, "R7 prea young");
    issue(0, P_NOP, 1, 0, 0, 1, 0, "R1 nop");
    issue(0, P_PRE, 1, 2, 1, 7, 0, "R7 prea mixed");
    issue(0, P_PRE, 1, 3, 0, 6, 0, "R7 pre idle");
    issue(0, P_ACT, 1, 1, 0, 2, 2, "R8 autopre closing");
    issue(0, P_MRS, 1, 0, 0, 9, 0, "R9 mrs idle");
    issue(0, P_NOP, 0, 0, 0, 11, 0, "R3 power down");
    issue(0, P_ACT, 0, 2, 0, 13, 0, "R3 hold");
    issue(0, P_NOP, 1, 0, 0, 14, 0, "R3 wake");
    issue(0, P_ACT, 1, 2, 0, 2, 0, "R3 held act ignored");
    issue(0, P_NOP, 0, 0, 0, 12, 0, "R3 suspend");
    issue(0, P_NOP, 1, 0, 0, 14, 0, "R3 wake");
    issue(0, P_REF, 0, 0, 0, 10, 2, "R3 sref open");
    issue(0, P_NOP, 1, 0, 0, 14, 0, "R3 wake");
    issue(0, P_PRE, 1, 2, 0, 6, 1, "R7 ras short");
    issue(0, P_PRE, 1, 2, 0, 6, 0, "R7 ras met");
    issue(0, P_NOP, 1, 0, 0, 1, 0, "R1 nop");
    issue(0, P_NOP, 1, 0, 0, 1, 0, "R1 nop");
    issue(0, P_REF, 0, 0, 0, 10, 0, "R3 sref idle");
    issue(0, P_ACT, 0, 1, 0, 13, 0, "R3 hold");
    issue(1, P_NOP, 1, 0, 0, 14, 0, "R3 wake");
    issue(0, P_REF, 1, 0, 0, 8, 0, "R9 aref idle");
    issue(1, P_MRS, 1, 3, 0, 0, 0, "R1 deselect");
    issue(0, P_BST, 1, 0, 0, 5, 0, "R1 burst stop");
    issue(0, P_RD,  1, 0, 1, 3, 2, "R4 R10 read closed");

    for (int k = 0; k < 400; k++) begin
      int r;
      bit [2:0] p;
      r = $urandom_range(0, 15);
      p = (r < 4) ? P_ACT : (r < 6) ? P_PRE : (r < 9) ? P_RD : (r < 11) ? P_WR :
          (r < 13) ? P_NOP : (r == 13) ? P_MRS : (r == 14) ? P_REF : P_BST;
      issue($urandom_range(0, 9) == 0, p, $urandom_range(0, 9) != 0,
            $urandom_range(0, 3), $urandom_range(0, 3) == 0, -1, -1, "R1 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule